// File: doc/BRIEF.md
# MDIO Management Frame Engine

This block runs one clause-22 management transaction on the two-wire PHY management bus each time software writes a 32-bit frame image into its frame register. It derives the management clock from the module clock through a programmable divider. It optionally sends a 32-bit run of ones before the frame. It serializes the image most significant bit first. For a read, it releases the data line during turnaround and the data phase and gathers the PHY's sixteen reply bits into the low half of the frame register.

Configuration lives in a separate speed register that holds the divider, a preamble-skip flag and an output hold count. Completion is reported through a sticky event bit. Software clears that bit by writing a one to it. The bidirectional pad is split into a driven value, an output enable and a sampled input. All control and status pins are plain one-cycle register strobes and levels. There is no streaming data path, so no valid/ready handshake applies.

Top module: `mdio_frame_engine`

## Requirements
- R1: After reset the engine is idle: `busy`, `mdc`, `mdio_oe` and `evt_mii` are low and `frame_rdata` is zero.
- R2: A `frame_wr` strobe while idle raises `busy` in the next cycle, and the written image reads back on `frame_rdata`.
- R3: The speed field in bits [6:1] of the speed register sets the management clock period to 2*(SPEED+1) module clock cycles.
- R4: Unless bit 7 of the speed register is set, 32 ones are sent with the output enabled before the frame. With bit 7 set, the frame starts immediately.
- R5: The 32-bit image is sent from bit 31 down to bit 0, one bit per management clock period, and the PHY samples it on the rising edge. The fields are: start [31:30] = 01, opcode [29:28] (10 read, 01 write), PHY address [27:23], register address [22:18], turnaround [17:16] = 10, data [15:0].
- R6: When opcode is 10, `mdio_oe` is low for frame bits 14 to 31 (turnaround and data). A write frame drives every bit.
- R7: During a read, `mdio_i` is sampled on each of the 16 data-phase rising edges, most significant bit first, into `frame_rdata[15:0]`.
- R8: `mdio_o` changes HOLD+1 module clock cycles after a falling edge of `mdc`, where HOLD is bits [10:8] of the speed register.
- R9: The falling edge that ends a frame sets `evt_mii`. A write with bit 23 of `evt_wdata` set clears it. A write with bit 23 clear leaves it set.
- R10: A `frame_wr` strobe while `busy` is high is ignored: the image and the frame on the wire are unchanged.
- R11: Whenever `busy` is low, `mdc` is low and `mdio_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_wr | input | 1 | Frame register write strobe; launches a transaction |
| frame_wdata | input | 32 | Frame image to send |
| frame_rdata | output | 32 | Frame register contents, with read data in [15:0] |
| speed_wr | input | 1 | Speed register write strobe |
| speed_wdata | input | 32 | Divider [6:1], preamble skip [7], hold [10:8] |
| evt_wr | input | 1 | Event register write strobe |
| evt_wdata | input | 32 | Write-one-to-clear mask; bit 23 clears the completion event |
| evt_mii | output | 1 | Sticky completion event |
| busy | output | 1 | Transaction in progress |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line value driven to the pad |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line value sampled from the pad |

## Verification
Some rules are checked by assertions on every cycle:
- the idle pad state, so the clock is low and the line released whenever the engine is not busy;
- the line being released whenever a read sample is taken;
- the upper image fields staying frozen while a frame runs;
- the completion event rising only on a frame's final edge.

Other behaviour shows only in the bench's scenarios, which compare against an independent bit model with a PHY model that answers reads:
- the exact bit sequence on the wire, including preamble and release positions;
- the management clock period for each divider value;
- the output hold delay after each falling edge;
- the reply assembled into the data field;
- the event clear semantics.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int FRAME_W    = 32;
  localparam int PRE_LEN    = 32;
  localparam int SPD_LSB    = 1;
  localparam int NOPRE_BIT  = 7;
  localparam int HOLD_LSB   = 8;
  localparam int EVT_BIT    = 23;
  localparam int OP_LO      = 28;
  localparam int TA_FIDX    = 14;   // first frame bit released on a read
  localparam int DATA_FIDX  = 16;   // first frame bit sampled on a read

  typedef enum logic [1:0] {
    OP_WRITE = 2'b01,
    OP_READ  = 2'b10
  } mgmt_op_e;
endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
  parameter int SPD_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [SPD_W-1:0] speed,
  output logic             mdc,
  output logic             rise,
  output logic             fall
);
  logic [SPD_W-1:0] cnt;
  logic             wrap;

  assign wrap = run && !restart && (cnt == speed);
  assign rise = wrap && !mdc;
  assign fall = wrap && mdc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (!run || restart) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (wrap) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/mdio_shift_engine.sv
module mdio_shift_engine
  import mdio_pkg::*;
#(
  parameter int HOLD_W = 3,
  parameter int PRE_W  = PRE_LEN
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               launch,
  input  logic               no_pre,
  input  logic [HOLD_W-1:0]  hold,
  input  logic               is_read,
  input  logic [FRAME_W-1:0] frame_in,
  input  logic               rise,
  input  logic               fall,
  input  logic               mdio_i,
  output logic               mdio_o,
  output logic               mdio_oe,
  output logic               done,
  output logic               sample_en,
  output logic               sample_bit
);
  localparam int SH_W  = PRE_W + FRAME_W;
  localparam int CNT_W = $clog2(SH_W + 1);

  logic [SH_W-1:0]   sh;
  logic [CNT_W-1:0]  total;
  logic [CNT_W-1:0]  nbits;
  logic [HOLD_W-1:0] hc;
  logic              pend;
  logic              rd_q;
  logic              active;
  int                drv_f;
  int                cur_f;

  // frame-relative index of the next bit to drive and of the bit on the wire
  assign drv_f = int'(nbits) + FRAME_W - int'(total);
  assign cur_f = drv_f - 1;

  assign done       = active && fall && (nbits == total);
  assign sample_en  = active && rise && rd_q && (cur_f >= DATA_FIDX);
  assign sample_bit = mdio_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh      <= '0;
      total   <= '0;
      nbits   <= '0;
      hc      <= '0;
      pend    <= 1'b0;
      rd_q    <= 1'b0;
      active  <= 1'b0;
      mdio_o  <= 1'b0;
      mdio_oe <= 1'b0;
    end else if (launch) begin
      sh     <= no_pre ? {frame_in, {PRE_W{1'b0}}} : {{PRE_W{1'b1}}, frame_in};
      total  <= no_pre ? CNT_W'(FRAME_W) : CNT_W'(SH_W);
      nbits  <= '0;
      hc     <= hold;
      pend   <= 1'b1;
      rd_q   <= is_read;
      active <= 1'b1;
    end else if (active) begin
      if (pend) begin
        if (hc == '0) begin
          mdio_o  <= sh[SH_W-1];
          mdio_oe <= !(rd_q && (drv_f >= TA_FIDX));
          sh      <= {sh[SH_W-2:0], 1'b0};
          nbits   <= nbits + 1'b1;
          pend    <= 1'b0;
        end else begin
          hc <= hc - 1'b1;
        end
      end
      if (fall) begin
        if (nbits == total) begin
          active  <= 1'b0;
          pend    <= 1'b0;
          mdio_o  <= 1'b0;
          mdio_oe <= 1'b0;
        end else begin
          pend <= 1'b1;
          hc   <= hold;
        end
      end
    end
  end

  // R6: a read sample is never taken while the engine drives the line
  assert_sample_released_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sample_en |-> !mdio_oe);

  // R5: never more bits driven than the frame holds
  assert_bit_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (nbits <= total));
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_pkg::*;
#(
  parameter int SPD_W  = 6,
  parameter int HOLD_W = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        frame_wr,
  input  logic [31:0] frame_wdata,
  output logic [31:0] frame_rdata,
  input  logic        speed_wr,
  input  logic [31:0] speed_wdata,
  input  logic        evt_wr,
  input  logic [31:0] evt_wdata,
  output logic        evt_mii,
  output logic        busy,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  logic [FRAME_W-1:0] img;
  logic [SPD_W-1:0]   speed_q;
  logic [HOLD_W-1:0]  hold_q;
  logic               nopre_q;
  logic               launch;
  logic               is_read;
  logic               rise;
  logic               fall;
  logic               done;
  logic               sample_en;
  logic               sample_bit;
  logic               unused_bits;

  assign launch      = frame_wr && !busy;
  assign is_read     = (frame_wdata[OP_LO+1:OP_LO] == OP_READ);
  assign frame_rdata = img;
  assign unused_bits = ^{speed_wdata[31:HOLD_LSB+HOLD_W], speed_wdata[0],
                         evt_wdata[31:EVT_BIT+1], evt_wdata[EVT_BIT-1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      speed_q <= '0;
      hold_q  <= '0;
      nopre_q <= 1'b0;
    end else if (speed_wr) begin
      speed_q <= speed_wdata[SPD_LSB +: SPD_W];
      hold_q  <= speed_wdata[HOLD_LSB +: HOLD_W];
      nopre_q <= speed_wdata[NOPRE_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      img     <= '0;
      busy    <= 1'b0;
      evt_mii <= 1'b0;
    end else begin
      if (launch) begin
        img  <= frame_wdata;
        busy <= 1'b1;
      end else begin
        if (sample_en) img[15:0] <= {img[14:0], sample_bit};
        if (done)      busy <= 1'b0;
      end
      if (done)                            evt_mii <= 1'b1;
      else if (evt_wr && evt_wdata[EVT_BIT]) evt_mii <= 1'b0;
    end
  end

  mdio_mdc_gen #(.SPD_W(SPD_W)) u_clk (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (busy),
    .restart (launch),
    .speed   (speed_q),
    .mdc     (mdc),
    .rise    (rise),
    .fall    (fall)
  );

  mdio_shift_engine #(.HOLD_W(HOLD_W)) u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .launch     (launch),
    .no_pre     (nopre_q),
    .hold       (hold_q),
    .is_read    (is_read),
    .frame_in   (frame_wdata),
    .rise       (rise),
    .fall       (fall),
    .mdio_i     (mdio_i),
    .mdio_o     (mdio_o),
    .mdio_oe    (mdio_oe),
    .done       (done),
    .sample_en  (sample_en),
    .sample_bit (sample_bit)
  );

  assert_idle_pads_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mdc && !mdio_oe));

  assert_busy_write_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(img[31:16]));

  assert_event_on_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(evt_mii) |-> $past(done));

  assert_done_while_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);
endmodule

// File: tb/tb_mdio_frame_engine.sv
`timescale 1ns/1ps
module tb_mdio_frame_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_wr = 1'b0;
  logic [31:0] frame_wdata = '0;
  logic [31:0] frame_rdata;
  logic        speed_wr = 1'b0;
  logic [31:0] speed_wdata = '0;
  logic        evt_wr = 1'b0;
  logic [31:0] evt_wdata = '0;
  logic        evt_mii, busy, mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  always #2.5 clk = ~clk;

  mdio_frame_engine dut (
    .clk(clk), .rst_n(rst_n), .frame_wr(frame_wr), .frame_wdata(frame_wdata),
    .frame_rdata(frame_rdata), .speed_wr(speed_wr), .speed_wdata(speed_wdata),
    .evt_wr(evt_wr), .evt_wdata(evt_wdata), .evt_mii(evt_mii), .busy(busy),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  // bench-side PHY model and bus monitor
  int          nr;
  logic        cap_o [64];
  logic        cap_oe [64];
  int          rise_t [64];
  int          since_fall;
  bit          fell;
  int          dmin, dmax;
  logic        prev_mdc = 1'b0;
  logic        prev_o = 1'b0;
  logic [15:0] resp;
  int          pre;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (busy) begin
      if (mdc && !prev_mdc) begin
        if (nr < 64) begin
          cap_o[nr]  = mdio_o;
          cap_oe[nr] = mdio_oe;
          rise_t[nr] = cyc;
        end
        nr++;
        begin
          int f = nr - pre;
          mdio_i = (f >= 16 && f <= 31) ? resp[31-f] : 1'b1;
        end
      end
      if (!mdc && prev_mdc) begin
        fell = 1'b1;
        since_fall = 0;
      end else begin
        since_fall++;
      end
      if (fell && since_fall > 0 && mdio_o !== prev_o) begin
        if (since_fall < dmin) dmin = since_fall;
        if (since_fall > dmax) dmax = since_fall;
      end
    end
    prev_mdc = mdc;
    prev_o   = mdio_o;
  end

  always @(posedge clk) begin
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL R2 watchdog actual=%0d expected<150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  function automatic logic [31:0] mk_img(input bit rd, input logic [4:0] phy, input logic [4:0] rg, input logic [15:0] d);
    return {2'b01, rd ? 2'b10 : 2'b01, phy, rg, 2'b10, rd ? 16'h0000 : d};
  endfunction

  task automatic start_frame(input logic [31:0] img, input logic [15:0] r, input bit nopre,
                             input logic [5:0] sp, input logic [2:0] hd);
    @(negedge clk);
    speed_wdata = {21'd0, hd, nopre, sp, 1'b0};
    speed_wr = 1'b1;
    @(negedge clk);
    speed_wr = 1'b0;
    resp = r; pre = nopre ? 0 : 32; nr = 0; fell = 1'b0;
    dmin = 1000; dmax = -1; mdio_i = 1'b1;
    frame_wdata = img;
    frame_wr = 1'b1;
    @(negedge clk);
    frame_wr = 1'b0;
    chk(busy === 1'b1, "R2 busy after launch", {31'd0, busy}, 32'd1);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 5000 && busy; i++) @(negedge clk);
  endtask

  task automatic cmp_bits(input logic [31:0] img, input bit rd, input bit nopre);
    int bad = 0;
    int p = nopre ? 0 : 32;
    int tot = p + 32;
    chk(nr == tot, "R4 rising edge count", nr, tot);
    for (int k = 0; k < 64; k++) begin
      if (k < tot) begin
        logic eo, eoe;
        int f = k - p;
        if (k < p) begin eo = 1'b1; eoe = 1'b1; end
        else begin eo = img[31-f]; eoe = !(rd && f >= 14); end
        if (cap_oe[k] !== eoe) bad++;
        else if (eoe && cap_o[k] !== eo) bad++;
      end
    end
    chk(bad == 0, "R5 R6 wire bits and release", bad, 0);
  endtask

  // rd, nopre, speed, hold, phy, reg, data/response
  localparam logic [36:0] VEC [0:4] = '{
    {1'b0, 1'b0, 6'd3, 3'd1, 5'h01, 5'h00, 16'h1140},
    {1'b1, 1'b0, 6'd2, 3'd0, 5'h1F, 5'h02, 16'hA5C3},
    {1'b1, 1'b1, 6'd4, 3'd3, 5'h0A, 5'h11, 16'h8001},
    {1'b0, 1'b1, 6'd1, 3'd0, 5'h00, 5'h1F, 16'hFFFF},
    {1'b0, 1'b0, 6'd5, 3'd4, 5'h10, 5'h04, 16'h0000}
  };

  initial begin
    #12;
    // R1 reset state
    chk(busy === 1'b0 && mdc === 1'b0 && mdio_oe === 1'b0, "R1 idle pins in reset",
        {busy, mdc, mdio_oe}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(evt_mii === 1'b0, "R1 event clear after reset", {31'd0, evt_mii}, 32'd0);
    chk(frame_rdata === 32'd0, "R1 frame register zero", frame_rdata, 32'd0);

    for (int v = 0; v < 5; v++) begin
      logic [36:0] e = VEC[v];
      bit rd = e[36];
      bit np = e[35];
      logic [5:0]  sp = e[34:29];
      logic [2:0]  hd = e[28:26];
      logic [31:0] img = mk_img(rd, e[25:21], e[20:16], e[15:0]);
      start_frame(img, e[15:0], np, sp, hd);
      wait_idle();
      @(negedge clk);
      cmp_bits(img, rd, np);
      chk(rise_t[1] - rise_t[0] == 2 * (int'(sp) + 1), "R3 mdc period",
          rise_t[1] - rise_t[0], 2 * (int'(sp) + 1));
      chk(dmin == int'(hd) + 1 && dmax == int'(hd) + 1, "R8 hold after falling edge",
          {dmin[15:0], dmax[15:0]}, int'(hd) + 1);
      if (rd) chk(frame_rdata === {img[31:16], e[15:0]}, "R7 read data in frame register",
                  frame_rdata, {img[31:16], e[15:0]});
      else    chk(frame_rdata === img, "R2 image readback", frame_rdata, img);
      chk(evt_mii === 1'b1, "R9 event set at completion", {31'd0, evt_mii}, 32'd1);
      chk(busy === 1'b0 && mdc === 1'b0 && mdio_oe === 1'b0, "R11 idle after frame",
          {busy, mdc, mdio_oe}, 32'd0);
      evt_wdata = 32'h0080_0000;
      evt_wr = 1'b1;
      @(negedge clk);
      evt_wr = 1'b0;
      chk(evt_mii === 1'b0, "R9 write one clears event", {31'd0, evt_mii}, 32'd0);
    end

    // R10 write during busy is ignored
    begin
      logic [31:0] a = mk_img(1'b0, 5'h03, 5'h07, 16'h5A5A);
      logic [31:0] b = mk_img(1'b1, 5'h1C, 5'h18, 16'h0000);
      start_frame(a, 16'h0000, 1'b1, 6'd2, 3'd1);
      repeat (3) @(negedge clk);
      frame_wdata = b;
      frame_wr = 1'b1;
      @(negedge clk);
      frame_wr = 1'b0;
      chk(frame_rdata === a, "R10 image kept while busy", frame_rdata, a);
      wait_idle();
      @(negedge clk);
      cmp_bits(a, 1'b0, 1'b1);
      chk(frame_rdata === a, "R10 first frame completes unchanged", frame_rdata, a);
    end

    // R9 writing zero at bit 23 leaves the event set
    evt_wdata = 32'hFF7F_FFFF;
    evt_wr = 1'b1;
    @(negedge clk);
    evt_wr = 1'b0;
    chk(evt_mii === 1'b1, "R9 write zero keeps event", {31'd0, evt_mii}, 32'd1);
    evt_wdata = 32'h0080_0000;
    evt_wr = 1'b1;
    @(negedge clk);
    evt_wr = 1'b0;
    chk(evt_mii === 1'b0, "R9 event cleared", {31'd0, evt_mii}, 32'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule